// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a synchronous requester and an asynchronous DRAM with multiplexed addressing. A requester raises `req` with a combined address, a direction bit and write data, and holds it until `ack` pulses. The sequencer then runs one complete memory cycle on the DRAM pins. It places the row half of the address on the shared pins and lowers `ras_n`. It then places the column half and lowers `cas_n`, together with `oe_n` for a read or with `we_n` and the data-drive enable for a write. Before the next cycle may start, it holds the strobe-low window for its minimum length and a full precharge.

A separate refresh scheduler raises `ref_req`. The sequencer serves it only from idle, never in the middle of an access, by running a CAS-before-RAS refresh cycle. It answers with a one-cycle `ref_ack`. Every DRAM timing value is a parameter counted in system clock cycles. The read sample point is derived as the latest of the four access-time limits. The `BIG_MAP` parameter selects 11 address pins (2K-refresh part) or 12 address pins (4K-refresh part).

Top module: `dram_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, and `dq_oe`, `ack` and `ref_ack` are low. All of them stay so while no request is pending.
- R2: `req_addr` is {row, column}, with the row in the upper pin-width bits. The row is driven on `dram_a` one cycle before `ras_n` falls and stays there for the T_RCD cycles for which `ras_n` is low and `cas_n` is high.
- R3: After the T_RCD cycles, `cas_n` falls and the column is driven on `dram_a`. `ras_n` stays low for LOW = max(T_RAS, K+1, T_RCD+T_CASW) cycles in total. K is defined in R5. `cas_n` returns high in the same cycle as `ras_n`.
- R4: After every cycle, all strobes stay high for at least max(T_RP, T_CP) cycles before `ras_n` may fall again.
- R5: On a read (`req_we`=0), `oe_n` falls with `cas_n` and `we_n` stays high. `dq_in` is sampled at the end of RAS-low cycle index K = max(T_RAC, T_RCD+max(T_CAC, T_AA, T_OEA)), with index 0 as the first low cycle. `ack` is high for the next cycle, and `rdata` holds the sample.
- R6: On a write (`req_wdata`, `req_we`=1), `we_n` falls with `cas_n`, and `dq_oe` is already high with `dq_out` equal to the write data in that cycle. `ack` is high in the first cycle after `ras_n` returns high.
- R7: `dq_oe` is never high while `oe_n` is low.
- R8: A refresh lowers `cas_n` for one cycle with `ras_n` high. It then holds both low for T_RAS cycles while `we_n` and `oe_n` stay high and `dq_oe` stays low. `ref_ack` is high in the first precharge cycle.
- R9: When `ref_req` and `req` are both pending in idle, the refresh runs first. The access starts in the idle cycle that follows the refresh precharge.
- R10: A `req` still held high during precharge after its `ack` does not start a new cycle. Once `req` is low on return to idle, the pins stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*PIN_W | {row, column} address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with ack on reads |
| ref_req | input | 1 | Refresh request from scheduler |
| ref_ack | output | 1 | One-cycle refresh completion pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_a | output | PIN_W | Multiplexed row/column address |
| dq_out | output | DW | Data driven to DRAM |
| dq_oe | output | 1 | Tristate enable for dq_out |
| dq_in | input | DW | Data returned by DRAM |

## Verification
Counting from the idle cycle in which a request is taken, the row appears one cycle later and `ras_n` falls two cycles later. `cas_n` falls T_RCD cycles after that. A read `ack` arrives K+3 cycles after the idle cycle and a write `ack` LOW+2 cycles after it, and precharge follows for max(T_RP, T_CP) cycles. The bench builds each cycle's expected pin state from these formulas into a queue and compares it on the falling clock edge. Its behavioural DRAM returns correct data only once every access-time limit has elapsed and the inverted value before that, so sampling even one cycle early shows up as wrong read data.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_CAS,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic sel_row;
    logic sel_col;
  } pin_ctl_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_ctl_t decode_pins(input seq_state_e st, input logic is_wr);
    pin_ctl_t p;
    p.ras_n   = !(st == ST_RAS || st == ST_CAS || st == ST_RRAS);
    p.cas_n   = !(st == ST_CAS || st == ST_RCAS || st == ST_RRAS);
    p.we_n    = !(st == ST_CAS && is_wr);
    p.oe_n    = !(st == ST_CAS && !is_wr);
    p.dq_oe   = (st == ST_CAS) && is_wr;
    p.sel_row = (st == ST_ROW) || (st == ST_RAS);
    p.sel_col = (st == ST_CAS);
    return p;
  endfunction

endpackage

// File: rtl/dram_seq_cnt.sv
module dram_seq_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  output logic [CW-1:0] k
);
  localparam logic [CW-1:0] K_TOP = '1;

  logic [CW-1:0] k_d;

  always_comb begin
    k_d = k;
    if (clr)              k_d = '0;
    else if (k != K_TOP)  k_d = k + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  k <= '0;
    else if (en) k <= k_d;
  end
endmodule

// File: rtl/dram_seq_amux.sv
module dram_seq_amux #(
  parameter int unsigned PIN_W = 11
) (
  input  logic             sel_row,
  input  logic             sel_col,
  input  logic [PIN_W-1:0] row,
  input  logic [PIN_W-1:0] col,
  output logic [PIN_W-1:0] a
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    assign a[i] = (sel_row & row[i]) | (sel_col & col[i]);
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned CW      = 4,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_RAS   = 6,
  parameter int unsigned LOW_CYC = 6,
  parameter int unsigned PRE_CYC = 3
) (
  input  seq_state_e    state_q,
  input  logic [CW-1:0] k,
  input  logic          req,
  input  logic          ref_req,
  output seq_state_e    state_d,
  output logic          k_clr,
  output logic          accept
);
  localparam logic [CW-1:0] K_RCD_END = CW'(T_RCD - 1);
  localparam logic [CW-1:0] K_LOW_END = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] K_REF_END = CW'(T_RAS - 1);
  localparam logic [CW-1:0] K_PRE_END = CW'(PRE_CYC - 1);

  always_comb begin
    state_d = state_q;
    k_clr   = 1'b0;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req) begin
          state_d = ST_RCAS;
        end else if (req) begin
          state_d = ST_ROW;
          accept  = 1'b1;
        end
      end
      ST_ROW: begin
        state_d = ST_RAS;
        k_clr   = 1'b1;
      end
      ST_RAS: begin
        if (k == K_RCD_END) state_d = ST_CAS;
      end
      ST_CAS: begin
        if (k == K_LOW_END) begin
          state_d = ST_PRE;
          k_clr   = 1'b1;
        end
      end
      ST_RCAS: begin
        state_d = ST_RRAS;
        k_clr   = 1'b1;
      end
      ST_RRAS: begin
        if (k == K_REF_END) begin
          state_d = ST_PRE;
          k_clr   = 1'b1;
        end
      end
      ST_PRE: begin
        if (k == K_PRE_END) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter bit          BIG_MAP = 1'b0,
  parameter int unsigned DW      = 8,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_RAS   = 6,
  parameter int unsigned T_CASW  = 2,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_CP    = 1,
  parameter int unsigned T_RAC   = 5,
  parameter int unsigned T_CAC   = 2,
  parameter int unsigned T_AA    = 3,
  parameter int unsigned T_OEA   = 2,
  localparam int unsigned PIN_W  = BIG_MAP ? 12 : 11,
  localparam int unsigned AW     = 2 * PIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  input  logic          ref_req,
  output logic          ref_ack,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [PIN_W-1:0] dram_a,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int unsigned K_CAP   = max2(T_RAC, T_RCD + max2(T_CAC, max2(T_AA, T_OEA)));
  localparam int unsigned LOW_CYC = max2(T_RAS, max2(K_CAP + 1, T_RCD + T_CASW));
  localparam int unsigned PRE_CYC = max2(T_RP, T_CP);
  localparam int unsigned CNT_TOP = max2(LOW_CYC, max2(PRE_CYC, T_RAS)) + 1;
  localparam int unsigned CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] K_CAP_C = CW'(K_CAP);
  localparam logic [CW-1:0] K_LOW_C = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] K_REF_C = CW'(T_RAS - 1);

  seq_state_e       state_q, state_d;
  logic [CW-1:0]    k;
  logic             k_clr, k_en, accept;
  logic [PIN_W-1:0] row_q, col_q, row_src, col_src, a_d;
  logic             we_q, we_src;
  logic [DW-1:0]    wdata_q;
  pin_ctl_t         pins_d;
  logic             cap_rd, ack_d, ref_ack_d;

  dram_seq_fsm #(
    .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .LOW_CYC(LOW_CYC), .PRE_CYC(PRE_CYC)
  ) u_fsm (
    .state_q(state_q), .k(k), .req(req), .ref_req(ref_req),
    .state_d(state_d), .k_clr(k_clr), .accept(accept)
  );

  assign k_en = (state_q != ST_IDLE);

  dram_seq_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(k_en), .clr(k_clr), .k(k)
  );

  // Sources for the registered pin decode: the request itself in the accept cycle
  assign row_src = accept ? req_addr[AW-1:PIN_W] : row_q;
  assign col_src = accept ? req_addr[PIN_W-1:0]  : col_q;
  assign we_src  = accept ? req_we : we_q;

  always_comb pins_d = decode_pins(state_d, we_src);

  dram_seq_amux #(.PIN_W(PIN_W)) u_amux (
    .sel_row(pins_d.sel_row), .sel_col(pins_d.sel_col),
    .row(row_src), .col(col_src), .a(a_d)
  );

  assign cap_rd    = (state_q == ST_CAS) && !we_q && (k == K_CAP_C);
  assign ack_d     = cap_rd || ((state_q == ST_CAS) && we_q && (k == K_LOW_C));
  assign ref_ack_d = (state_q == ST_RRAS) && (k == K_REF_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dram_a  <= '0;
      ack     <= 1'b0;
      ref_ack <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ras_n   <= pins_d.ras_n;
      cas_n   <= pins_d.cas_n;
      we_n    <= pins_d.we_n;
      oe_n    <= pins_d.oe_n;
      dq_oe   <= pins_d.dq_oe;
      dram_a  <= a_d;
      ack     <= ack_d;
      ref_ack <= ref_ack_d;
      if (accept) we_q <= req_we;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      row_q   <= req_addr[AW-1:PIN_W];
      col_q   <= req_addr[PIN_W-1:0];
      wdata_q <= req_wdata;
    end
    if (cap_rd) rdata <= dq_in;
  end

  assign dq_out = wdata_q;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_CP  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  localparam int unsigned PRE_MIN = (T_RP > T_CP) ? T_RP : T_CP;
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'(PRE_MIN);
    end else begin
      lo_cnt <= ras_n ? '0 : ((lo_cnt == SAT) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt == SAT) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= 16'(T_RAS))); // R3
  AST_STROBES_END_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n); // R3
  AST_PRECHARGE_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(PRE_MIN))); // R4
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n); // R5
  AST_WRITE_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (!cas_n && dq_oe)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R7
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (we_n && oe_n && !dq_oe)); // R8
endmodule

bind dram_seq dram_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
  localparam int BT_RCD = 2, BT_RAS = 6, BT_CASW = 2, BT_RP = 3, BT_CP = 1;
  localparam int BT_RAC = 5, BT_CAC = 2, BT_AA = 3, BT_OEA = 2;
  localparam int PW = 11, AW = 22, DW = 8;
  localparam int COLK = (BT_CAC > BT_AA) ? ((BT_CAC > BT_OEA) ? BT_CAC : BT_OEA)
                                         : ((BT_AA > BT_OEA) ? BT_AA : BT_OEA);
  localparam int KC = (BT_RAC > BT_RCD + COLK) ? BT_RAC : BT_RCD + COLK;
  localparam int LC0 = (BT_RAS > KC + 1) ? BT_RAS : KC + 1;
  localparam int LC = (LC0 > BT_RCD + BT_CASW) ? LC0 : BT_RCD + BT_CASW;
  localparam int PC = (BT_RP > BT_CP) ? BT_RP : BT_CP;

  typedef struct packed {
    logic ras, cas, we, oe, doe, ack, rack, chka;
    logic [PW-1:0] a;
  } pin_t;
  localparam pin_t IDLE_V = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dq_in = '0;
  logic ack, ref_ack, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [PW-1:0] dram_a;

  int checks = 0, errors = 0;
  bit run = 1'b0;
  pin_t exp_q[$];
  string tag_q[$];
  logic [DW-1:0] dram_mem[int];
  logic [DW-1:0] ref_mem[int];
  int kr = 0, kc = 0;
  logic [PW-1:0] row_l = '0, col_l = '0;

  always #5 clk = ~clk;

  dram_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .ref_req(ref_req),
    .ref_ack(ref_ack), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dram_a(dram_a), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Per-cycle pin comparison plus a behavioural DRAM
  always @(negedge clk) begin
    pin_t e, a;
    string t;
    logic [DW-1:0] val;
    if (run) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = IDLE_V;
        t = "R1";
      end
      a = '{ras_n, cas_n, we_n, oe_n, dq_oe, ack, ref_ack, e.chka, e.chka ? dram_a : '0};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s pins actual %h expected %h at %0t", t, a, e, $time);
      end
      checks++;
      if (dq_oe && !oe_n) begin
        errors++;
        $display("FAIL R7 dq_oe actual 1 expected 0 while oe_n low");
      end
      if (!ras_n) kr++; else kr = 0;
      if (!cas_n) kc++; else kc = 0;
      if (!ras_n && kr == 1) row_l = dram_a;
      if (!ras_n && !cas_n && kc == 1) begin
        col_l = dram_a;
        if (!we_n) begin
          checks++;
          if (dq_oe !== 1'b1) begin
            errors++;
            $display("FAIL R6 dq_oe at write strobe actual %b expected 1", dq_oe);
          end
          dram_mem[int'({row_l, col_l})] = dq_out;
        end
      end
      val = dram_mem.exists(int'({row_l, col_l})) ? dram_mem[int'({row_l, col_l})] : '0;
      dq_in = (!ras_n && !cas_n && !oe_n && (kr - 1) >= BT_RAC && (kc - 1) >= COLK) ? val : ~val;
    end
  end

  function automatic void push_access(bit we, logic [PW-1:0] r, logic [PW-1:0] c, string pre);
    for (int o = 0; o < 2 + LC + PC; o++) begin
      pin_t v;
      int k;
      bit cl;
      string t;
      k = o - 2;
      v = IDLE_V;
      cl = (o >= 2) && (k >= BT_RCD) && (k < LC);
      if (o >= 2 && k < LC) v.ras = 1'b0;
      if (cl) begin
        v.cas = 1'b0; v.we = !we; v.oe = we; v.doe = we; v.chka = 1'b1; v.a = c;
      end
      if (o == 1 || (o >= 2 && k < BT_RCD)) begin
        v.chka = 1'b1; v.a = r;
      end
      v.ack = we ? (k == LC) : (k == KC + 1);
      t = (o == 0) ? "R1" : (o < 2 + BT_RCD) ? "R2" : cl ? "R3" : "R4";
      if (v.ack) t = we ? "R6" : "R5";
      exp_q.push_back(v);
      tag_q.push_back({pre, t});
    end
  endfunction

  function automatic void push_refresh(string pre);
    for (int o = 0; o < 2 + BT_RAS + PC; o++) begin
      pin_t v;
      int k;
      k = o - 2;
      v = IDLE_V;
      if (o == 1) v.cas = 1'b0;
      if (o >= 2 && k < BT_RAS) begin v.ras = 1'b0; v.cas = 1'b0; end
      v.rack = (k == BT_RAS);
      exp_q.push_back(v);
      tag_q.push_back({pre, "R8"});
    end
  endfunction

  task automatic run_loop(int hold, bit is_rd, logic [AW-1:0] ad);
    int hc = -1;
    while (exp_q.size() > 0) begin
      @(posedge clk); #1;
      if (ref_ack) ref_req = 1'b0;
      if (ack) begin
        hc = hold;
        if (is_rd) begin
          checks++;
          if (rdata !== ref_mem[int'(ad)]) begin
            errors++;
            $display("FAIL R5 rdata actual %h expected %h", rdata, ref_mem[int'(ad)]);
          end
        end
      end
      if (hc == 0) begin req = 1'b0; hc = -1; end
      else if (hc > 0) hc--;
    end
  endtask

  task automatic access(bit we, logic [AW-1:0] ad, logic [DW-1:0] d, int hold, bit with_ref);
    @(posedge clk); #1;
    req = 1'b1; req_we = we; req_addr = ad; req_wdata = d;
    if (we) ref_mem[int'(ad)] = d;
    else if (!ref_mem.exists(int'(ad))) ref_mem[int'(ad)] = '0;
    if (with_ref) begin
      ref_req = 1'b1;
      push_refresh("R9/");
      push_access(we, ad[AW-1:PW], ad[PW-1:0], "R9/");
    end else begin
      push_access(we, ad[AW-1:PW], ad[PW-1:0], "");
    end
    run_loop(hold, !we, ad);
  endtask

  task automatic refresh_only();
    @(posedge clk); #1;
    ref_req = 1'b1;
    push_refresh("");
    run_loop(0, 1'b0, '0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(posedge clk);                      // R1 idle after reset
    access(1'b1, 22'h00A_055, 8'h5A, 0, 1'b0);     // R6 write
    access(1'b0, 22'h00A_055, 8'h00, 0, 1'b0);     // R5 read back
    access(1'b1, 22'h3FF_800, 8'hC3, 0, 1'b0);     // R2 top row, column zero
    access(1'b1, 22'h3FF_FFF, 8'h81, 0, 1'b0);     // R2 all-ones address
    access(1'b0, 22'h3FF_800, 8'h00, 0, 1'b0);
    access(1'b0, 22'h3FF_FFF, 8'h00, 0, 1'b0);
    refresh_only();                                 // R8
    access(1'b0, 22'h00A_055, 8'h00, 0, 1'b0);     // data survives refresh
    access(1'b0, 22'h3FF_800, 8'h00, 0, 1'b1);     // R9 refresh wins
    access(1'b1, 22'h155_2AA, 8'h3C, 0, 1'b1);     // R9 with a write
    access(1'b1, 22'h001_001, 8'h77, 2, 1'b0);     // R10 req held into precharge
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(IDLE_V);
      tag_q.push_back("R10");
    end
    run_loop(0, 1'b0, '0);
    access(1'b0, 22'h001_001, 8'h00, 0, 1'b0);
    access(1'b0, 22'h155_2AA, 8'h00, 0, 1'b0);
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule